// File: doc/BRIEF.md
# Anisotropic Sample Position Generator

This block turns one anisotropy sampling line into a stream of bilinear tap positions, each with an unnormalized weight. A request carries the two endpoints of the line in unsigned fixed-point texel coordinates, with `FRAC_W` fraction bits. The block picks the axis along which the line is longer and walks along that axis from the lower end to the higher end. It emits the true start point, then every interior tap, then the true end point.

Interior taps are locked to a fixed grid on the major axis. The grid holds the positions that are 0.5 texel past a multiple of 2.0 texels. Each interior tap therefore straddles two whole texels, and consecutive interior taps are two texels apart. When the line moves slowly from frame to frame, the interior taps do not move along the major axis. Only their minor-axis coordinate slides along the line, and only the two end taps and their weights change.

The minor-axis slope is computed once per request by a sequential divider that takes `SLOPE_FRAC+1` cycles. After that, one sample can leave per clock. Both sides use valid/ready.

- **Request side:** a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no line is in progress.
- **Sample side:** a sample is consumed on a clock edge where `smp_valid` and `smp_ready` are both high. While `smp_ready` is low, the block holds the presented sample unchanged and does not drop it.

Top module: `aniso_sample_gen`

## Requirements
- R1: After reset, `req_ready` is 1 and `smp_valid` is 0. `req_ready` is 0 from the cycle after a request is accepted until the last sample of that line has been consumed. After that, `smp_valid` is 0 and `req_ready` is 1 again.
- R2: The u axis is major when |u1-u0| >= |v1-v0|; otherwise v is major. Ties go to u. `smp_vmajor` is 1 exactly when v is major.
- R3: Samples come out in strictly increasing major-axis order. The endpoints are swapped when the second one has the smaller major coordinate. The first sample is the endpoint with the smaller major coordinate, the last sample is the other endpoint, and `smp_last` is 1 only on the final sample.
- R4: Interior samples sit on the grid where the major coordinate modulo 2.0 equals 0.5. In raw units, the low `FRAC_W+1` bits equal `1<<(FRAC_W-1)`. Every grid point strictly between the two endpoints is emitted, and only those, so consecutive interior samples differ by exactly 2.0.
- R5: The minor coordinate of an interior sample at major position x is floor((ms·2^S ± q·(x−s)) / 2^S). Here s and ms are the start point, S is `SLOPE_FRAC`, and q = floor(|Δminor|·2^S / Δmajor). The sign is minus when the minor coordinate falls along the line.
- R6: Every interior sample has weight 2.0 (raw value `2<<FRAC_W`).
- R7: The start weight is the distance from the start to the first interior sample. The end weight is the distance from the last interior sample to the end. When there is no interior sample, both endpoint weights equal the major-axis length.
- R8: A line whose endpoints coincide yields a single sample at that point, with weight 2.0 and `smp_last` = 1.
- R9: While `smp_valid` is 1 and `smp_ready` is 0, the sample outputs stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, will take a request |
| req_u0 | input | COORD_W | First endpoint, u coordinate |
| req_v0 | input | COORD_W | First endpoint, v coordinate |
| req_u1 | input | COORD_W | Second endpoint, u coordinate |
| req_v1 | input | COORD_W | Second endpoint, v coordinate |
| smp_valid | output | 1 | Sample presented |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_u | output | COORD_W | Sample u coordinate |
| smp_v | output | COORD_W | Sample v coordinate |
| smp_w | output | COORD_W | Unnormalized sample weight |
| smp_last | output | 1 | Final sample of the line |
| smp_vmajor | output | 1 | v is the major axis for this line |

## Verification
The bench aims at the edges of the grid walk:
- **Start or end exactly on a grid point.** A design that used >= instead of > would emit a zero-weight duplicate tap.
- **Lines short enough to contain no interior tap.** A wrong design would emit a grid point outside the line or a garbage endpoint weight.
- **Equal |du| and |dv|.** A wrong tie rule flips the axis.
- **Reversed endpoints and falling minor coordinates.** These expose a missing swap or a wrong slope sign.
- **Zero-length lines.** These can hang the divider or emit two samples.
- **A 16-texel line from 0.0 to 16.0.** This must give the start tap, 8 interior taps and the end tap.

Random stalls on `smp_ready` expose any sample that changes or is lost under back-pressure.

// File: rtl/aniso_pkg.sv
`timescale 1ns/1ps
package aniso_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DIV   = 3'd1,
    ST_FIRST = 3'd2,
    ST_MID   = 3'd3,
    ST_FINAL = 3'd4
  } walk_state_e;
endpackage

// File: rtl/aniso_axis_sel.sv
`timescale 1ns/1ps
// Picks the major axis, orders the endpoints along it and finds the
// first grid position strictly past the start.
module aniso_axis_sel #(
  parameter int COORD_W = 12,
  parameter int FRAC_W  = 4
) (
  input  logic [COORD_W-1:0] u0,
  input  logic [COORD_W-1:0] v0,
  input  logic [COORD_W-1:0] u1,
  input  logic [COORD_W-1:0] v1,
  output logic               v_major,
  output logic [COORD_W-1:0] maj_s,
  output logic [COORD_W-1:0] maj_e,
  output logic [COORD_W-1:0] min_s,
  output logic [COORD_W-1:0] min_e,
  output logic [COORD_W-1:0] maj_len,
  output logic [COORD_W-1:0] min_len,
  output logic               min_neg,
  output logic [COORD_W+1:0] grid0
);
  localparam int MW = FRAC_W + 1;
  localparam logic [COORD_W+1:0] HALF   = (COORD_W+2)'(1) << (FRAC_W - 1);
  localparam logic [COORD_W+1:0] STRIDE = (COORD_W+2)'(1) << MW;

  logic [COORD_W-1:0] adu, adv, maj_a, maj_b, min_a, min_b;
  logic               swap;

  always_comb begin
    adu     = (u1 >= u0) ? u1 - u0 : u0 - u1;
    adv     = (v1 >= v0) ? v1 - v0 : v0 - v1;
    v_major = adv > adu;
    maj_a   = v_major ? v0 : u0;
    maj_b   = v_major ? v1 : u1;
    min_a   = v_major ? u0 : v0;
    min_b   = v_major ? u1 : v1;
    swap    = maj_b < maj_a;
    maj_s   = swap ? maj_b : maj_a;
    maj_e   = swap ? maj_a : maj_b;
    min_s   = swap ? min_b : min_a;
    min_e   = swap ? min_a : min_b;
    maj_len = maj_e - maj_s;
    min_neg = min_e < min_s;
    min_len = min_neg ? min_s - min_e : min_e - min_s;
    grid0   = {2'b00, maj_s[COORD_W-1:MW], {MW{1'b0}}} + HALF;
    if (maj_s[MW-1:0] >= HALF[MW-1:0]) grid0 = grid0 + STRIDE;
  end
endmodule

// File: rtl/aniso_slope_div.sv
`timescale 1ns/1ps
// Restoring divider for num/den with num <= den: quotient in [0, 1.0]
// carrying QF fraction bits, one quotient bit per cycle.
module aniso_slope_div #(
  parameter int NW = 12,
  parameter int QF = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [QF:0]   quot
);
  localparam int CNT_W = $clog2(QF + 1);

  logic [NW:0]    rem, trial, den_x;
  logic [NW-1:0]  den_q;
  logic [CNT_W-1:0] cnt;
  logic           first;

  always_comb begin
    den_x = {1'b0, den_q};
    trial = first ? rem : {rem[NW-1:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      den_q <= '0;
      cnt   <= '0;
      first <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      quot  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= {1'b0, num};
        den_q <= den;
        quot  <= '0;
        cnt   <= CNT_W'(QF);
        first <= 1'b1;
        busy  <= 1'b1;
      end else if (busy) begin
        first <= 1'b0;
        if (trial >= den_x) begin
          quot <= {quot[QF-1:0], 1'b1};
          rem  <= trial - den_x;
        end else begin
          quot <= {quot[QF-1:0], 1'b0};
          rem  <= trial;
        end
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R5: the operands never describe a slope steeper than 1.0
  p_num_le_den_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (num <= den && den != '0));
  // R5: the finished quotient stays within 1.0
  p_slope_le_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (quot <= ((QF+1)'(1) << QF)));
endmodule

// File: rtl/aniso_minor_acc.sv
`timescale 1ns/1ps
// Minor-axis position along the line, kept with SLOPE_FRAC extra bits.
module aniso_minor_acc #(
  parameter int COORD_W    = 12,
  parameter int FRAC_W     = 4,
  parameter int SLOPE_FRAC = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic [COORD_W-1:0]  min_start,
  input  logic [COORD_W+1:0]  offset,
  input  logic [SLOPE_FRAC:0] slope,
  input  logic                neg,
  output logic [COORD_W-1:0]  minor
);
  localparam int AW = COORD_W + SLOPE_FRAC + 4;

  logic [AW-1:0] acc, prod, stepv, base;

  always_comb begin
    prod  = AW'(slope) * AW'(offset);
    stepv = AW'(slope) << (FRAC_W + 1);
    base  = AW'(min_start) << SLOPE_FRAC;
    minor = acc[COORD_W+SLOPE_FRAC-1:SLOPE_FRAC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (load) begin
      acc <= neg ? base - prod : base + prod;
    end else if (step) begin
      acc <= neg ? acc - stepv : acc + stepv;
    end
  end
endmodule

// File: rtl/aniso_sample_gen.sv
`timescale 1ns/1ps
module aniso_sample_gen #(
  parameter int COORD_W    = 12,
  parameter int FRAC_W     = 4,
  parameter int SLOPE_FRAC = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] req_u0,
  input  logic [COORD_W-1:0] req_v0,
  input  logic [COORD_W-1:0] req_u1,
  input  logic [COORD_W-1:0] req_v1,
  output logic               smp_valid,
  input  logic               smp_ready,
  output logic [COORD_W-1:0] smp_u,
  output logic [COORD_W-1:0] smp_v,
  output logic [COORD_W-1:0] smp_w,
  output logic               smp_last,
  output logic               smp_vmajor
);
  import aniso_pkg::*;

  localparam int GW = COORD_W + 2;
  localparam logic [GW-1:0] STRIDE = GW'(1) << (FRAC_W + 1);
  localparam logic [GW-1:0] HALF   = GW'(1) << (FRAC_W - 1);

  walk_state_e state;

  // setup view of the incoming request
  logic               c_vmaj, c_neg;
  logic [COORD_W-1:0] c_s, c_e, c_ms, c_me, c_len, c_mlen;
  logic [GW-1:0]      c_g0;

  aniso_axis_sel #(.COORD_W(COORD_W), .FRAC_W(FRAC_W)) u_axis (
    .u0(req_u0), .v0(req_v0), .u1(req_u1), .v1(req_v1),
    .v_major(c_vmaj), .maj_s(c_s), .maj_e(c_e), .min_s(c_ms), .min_e(c_me),
    .maj_len(c_len), .min_len(c_mlen), .min_neg(c_neg), .grid0(c_g0)
  );

  logic accept, fire;
  logic div_start, div_busy, div_done;
  logic [SLOPE_FRAC:0] slope;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign div_start = accept && (c_len != '0);

  aniso_slope_div #(.NW(COORD_W), .QF(SLOPE_FRAC)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(c_mlen), .den(c_len),
    .busy(div_busy), .done(div_done), .quot(slope)
  );

  // per-line registers
  logic               vmaj_q, neg_q, zero_q, mid_q;
  logic [COORD_W-1:0] s_q, e_q, ms_q, me_q, len_q;
  logic [GW-1:0]      g0_q, pos_q, pos_nxt;
  logic [COORD_W-1:0] minor_acc;

  aniso_minor_acc #(.COORD_W(COORD_W), .FRAC_W(FRAC_W), .SLOPE_FRAC(SLOPE_FRAC)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(div_done), .step(fire && state == ST_MID),
    .min_start(ms_q), .offset(g0_q - {2'b00, s_q}), .slope(slope), .neg(neg_q),
    .minor(minor_acc)
  );

  assign pos_nxt = pos_q + STRIDE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      vmaj_q <= 1'b0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      mid_q  <= 1'b0;
      s_q    <= '0;
      e_q    <= '0;
      ms_q   <= '0;
      me_q   <= '0;
      len_q  <= '0;
      g0_q   <= '0;
      pos_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          vmaj_q <= c_vmaj;
          neg_q  <= c_neg;
          zero_q <= (c_len == '0);
          mid_q  <= (c_g0 < {2'b00, c_e});
          s_q    <= c_s;
          e_q    <= c_e;
          ms_q   <= c_ms;
          me_q   <= c_me;
          len_q  <= c_len;
          g0_q   <= c_g0;
          pos_q  <= c_g0;
          state  <= (c_len == '0) ? ST_FIRST : ST_DIV;
        end
        ST_DIV: if (div_done) state <= ST_FIRST;
        ST_FIRST: if (fire) begin
          if (zero_q)     state <= ST_IDLE;
          else if (mid_q) state <= ST_MID;
          else            state <= ST_FINAL;
        end
        ST_MID: if (fire) begin
          pos_q <= pos_nxt;
          if (pos_nxt >= {2'b00, e_q}) state <= ST_FINAL;
        end
        ST_FINAL: if (fire) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // output selection
  logic [COORD_W-1:0] out_major, out_minor;
  logic [GW-1:0]      w_full;

  always_comb begin
    out_major = s_q;
    out_minor = ms_q;
    w_full    = STRIDE;
    smp_last  = 1'b0;
    unique case (state)
      ST_FIRST: begin
        out_major = s_q;
        out_minor = ms_q;
        if (zero_q)     w_full = STRIDE;
        else if (mid_q) w_full = g0_q - {2'b00, s_q};
        else            w_full = {2'b00, len_q};
        smp_last = zero_q;
      end
      ST_MID: begin
        out_major = pos_q[COORD_W-1:0];
        out_minor = minor_acc;
        w_full    = STRIDE;
      end
      ST_FINAL: begin
        out_major = e_q;
        out_minor = me_q;
        w_full    = mid_q ? ({2'b00, e_q} + STRIDE - pos_q) : {2'b00, len_q};
        smp_last  = 1'b1;
      end
      default: ;
    endcase
  end

  assign smp_valid  = (state == ST_FIRST) || (state == ST_MID) || (state == ST_FINAL);
  assign fire       = smp_valid && smp_ready;
  assign smp_u      = vmaj_q ? out_minor : out_major;
  assign smp_v      = vmaj_q ? out_major : out_minor;
  assign smp_w      = w_full[COORD_W-1:0];
  assign smp_vmajor = vmaj_q;

  // R1: no sample is offered while a new request can be taken
  p_idle_no_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !smp_valid);
  // R9: a stalled sample holds its value
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_u) && $stable(smp_v)
                                   && $stable(smp_w) && $stable(smp_last)));
  // R3: each consumed non-final sample is followed by one further along the major axis
  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !smp_last) |=> (smp_valid && out_major > $past(out_major)));
  // R4: interior taps sit on the half-texel grid strictly inside the line
  p_grid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MID) |-> (pos_q[FRAC_W:0] == HALF[FRAC_W:0]
                           && out_major > s_q && out_major < e_q));
  // R7: every weight is positive and at most one stride
  p_weight_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (w_full != '0 && w_full <= STRIDE));
endmodule

// File: tb/sim_aniso_sample_gen.sv
`timescale 1ns/1ps
module sim_aniso_sample_gen;
  localparam int CW = 12;
  localparam int FW = 4;
  localparam int SF = 12;
  localparam int STRIDE = 2 << FW;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [CW-1:0] req_u0 = '0, req_v0 = '0, req_u1 = '0, req_v1 = '0;
  logic          smp_valid, smp_ready = 1'b0, smp_last, smp_vmajor;
  logic [CW-1:0] smp_u, smp_v, smp_w;

  aniso_sample_gen #(.COORD_W(CW), .FRAC_W(FW), .SLOPE_FRAC(SF)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_u0(req_u0), .req_v0(req_v0), .req_u1(req_u1), .req_v1(req_v1),
    .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_u(smp_u), .smp_v(smp_v), .smp_w(smp_w),
    .smp_last(smp_last), .smp_vmajor(smp_vmajor)
  );

  int checks = 0;
  int errors = 0;
  int eu[0:255], ev[0:255], ew[0:255];
  int en;
  int eaxis;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int iabs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int clampc(input int x);
    return (x < 0) ? 0 : ((x > MAXC) ? MAXC : x);
  endfunction

  function automatic void push(input int vm, input int maj, input int mn, input int w);
    eu[en] = vm ? mn : maj;
    ev[en] = vm ? maj : mn;
    ew[en] = w;
    en++;
  endfunction

  // expected sample list from the requirements
  function automatic void build(input int u0, input int v0, input int u1, input int v1);
    int vm, a0, a1, b0, b1, t, dm, g, x, lastx, sgn;
    longint q, acc;
    vm = (iabs(v1 - v0) > iabs(u1 - u0)) ? 1 : 0;
    a0 = vm ? v0 : u0;  a1 = vm ? v1 : u1;
    b0 = vm ? u0 : v0;  b1 = vm ? u1 : v1;
    if (a1 < a0) begin
      t = a0; a0 = a1; a1 = t;
      t = b0; b0 = b1; b1 = t;
    end
    en = 0;
    eaxis = vm;
    dm = a1 - a0;
    if (dm == 0) begin
      push(vm, a0, b0, STRIDE);
      return;
    end
    q = (longint'(iabs(b1 - b0)) << SF) / dm;
    sgn = (b1 < b0) ? -1 : 1;
    g = a0 - (a0 % STRIDE) + (STRIDE / 4);
    if (g <= a0) g += STRIDE;
    push(vm, a0, b0, (g < a1) ? g - a0 : dm);
    x = g;
    lastx = a0;
    while (x < a1) begin
      acc = (longint'(b0) << SF) + longint'(sgn) * q * longint'(x - a0);
      push(vm, x, int'(acc >>> SF), STRIDE);
      lastx = x;
      x += STRIDE;
    end
    push(vm, a1, b1, (g < a1) ? a1 - lastx : dm);
  endfunction

  task automatic run(input int u0, input int v0, input int u1, input int v1);
    int idx, cyc;
    bit stalled;
    logic [CW-1:0] hu, hv, hw;
    logic hl;
    string tag;
    build(u0, v0, u1, v1);
    @(negedge clk);
    req_u0 = CW'(u0); req_v0 = CW'(v0); req_u1 = CW'(u1); req_v1 = CW'(v1);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    idx = 0; cyc = 0; stalled = 1'b0;
    hu = '0; hv = '0; hw = '0; hl = 1'b0;
    while (idx < en && cyc < 4000) begin
      smp_ready = ($urandom % 4) != 0;
      #1;
      if (stalled)
        chk(smp_valid && smp_u == hu && smp_v == hv && smp_w == hw && smp_last == hl,
            $sformatf("R9 held sample changed: got v=%0b u=%0d v=%0d w=%0d exp u=%0d v=%0d w=%0d",
                      smp_valid, smp_u, smp_v, smp_w, hu, hv, hw));
      if (smp_valid && smp_ready) begin
        if (en == 1) tag = "R8";
        else if (idx == 0 || idx == en - 1) tag = "R3 R7";
        else tag = "R4 R5 R6";
        chk(int'(smp_u) == eu[idx] && int'(smp_v) == ev[idx] && int'(smp_w) == ew[idx]
            && smp_last == (idx == en - 1) && int'(smp_vmajor) == eaxis,
            $sformatf("%s R2 line (%0d,%0d)-(%0d,%0d) sample %0d: got u=%0d v=%0d w=%0d last=%0b ax=%0b exp u=%0d v=%0d w=%0d last=%0b ax=%0d",
                      tag, u0, v0, u1, v1, idx, smp_u, smp_v, smp_w, smp_last, smp_vmajor,
                      eu[idx], ev[idx], ew[idx], (idx == en - 1), eaxis));
        if (idx == 0)
          chk(!req_ready, $sformatf("R1 busy line: got req_ready=%0b exp 0", req_ready));
        idx++;
        stalled = 1'b0;
      end else if (smp_valid) begin
        hu = smp_u; hv = smp_v; hw = smp_w; hl = smp_last;
        stalled = 1'b1;
      end else begin
        stalled = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    chk(idx == en, $sformatf("R3 sample count line (%0d,%0d)-(%0d,%0d): got %0d exp %0d",
                             u0, v0, u1, v1, idx, en));
    smp_ready = 1'b0;
    #1;
    chk(!smp_valid && req_ready,
        $sformatf("R1 R3 after last sample: got valid=%0b ready=%0b exp valid=0 ready=1",
                  smp_valid, req_ready));
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && !smp_valid,
        $sformatf("R1 reset state: got ready=%0b valid=%0b exp ready=1 valid=0", req_ready, smp_valid));
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready && !smp_valid,
        $sformatf("R1 after reset release: got ready=%0b valid=%0b exp ready=1 valid=0", req_ready, smp_valid));

    run(100, 200, 100, 200);     // R8 zero length
    run(80, 0, 80, 256);         // R4 16-texel footprint: 8 interior taps
    run(80, 256, 80, 0);         // R3 reversed
    run(0, 0, 160, 160);         // R2 tie picks u
    run(0, 0, 160, 161);         // R2 v by one
    run(300, 50, 20, 900);       // R5 falling minor, steep
    run(8, 30, 72, 10);          // R4 R7 start and end on grid
    run(9, 5, 30, 6);            // R7 no interior tap
    run(39, 0, 41, 0);           // R4 one grid point just inside
    run(40, 0, 41, 1);           // R7 start on grid, tiny line
    run(4000, 4095, 4095, 0);    // top of range
    run(0, 4095, 4095, 4095);    // longest line

    for (int i = 0; i < 300; i++) begin
      int a, b, c, d, m;
      a = $urandom % (MAXC + 1);
      b = $urandom % (MAXC + 1);
      m = $urandom % 4;
      if (m == 0) begin
        c = clampc(a + int'($urandom % 81) - 40);
        d = clampc(b + int'($urandom % 81) - 40);
      end else if (m == 1) begin
        int k;
        k = int'($urandom % 600) - 300;
        c = clampc(a + k);
        d = clampc(b + (((i % 2) == 0) ? k : -k));
      end else begin
        c = $urandom % (MAXC + 1);
        d = $urandom % (MAXC + 1);
      end
      run(a, b, c, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule